// File: doc/BRIEF.md
# Endpoint FIFO Access Controller

This block sits between a microcontroller's register bus and four byte-wide endpoint queues of a USB device function. One 8-bit command/status register lets firmware choose an endpoint, state which way the bytes travel, raise a request and wipe a queue. Four data-port addresses, one per endpoint, move bytes between firmware and the selected queue while the block reports itself ready. A second register carries the line-health flags and the interrupt filter setting.

The serial engine is represented by a plain event interface. It can push received bytes into any queue and pop bytes for transmission. It pulses the SETUP, zero-length and CRC-error inputs, holds the end-of-transaction level, and reports each IN/OUT token with its endpoint and whether it was NAKed. From those token reports the block forms a one-cycle interrupt pulse.

A handshake state machine follows the request and direction bits. Its states are `HS_IDLE`, `HS_WRITE`, `HS_WR_CLOSE`, `HS_READ` and `HS_RD_DONE`, and its transitions are these:
- idle→write when request=1 and direction=1.
- idle→read when request=1 and direction=0.
- write→write-close when direction falls while the request stays up.
- read→read-done when direction rises while the request stays up.
- Any state→idle when the request drops or a bus reset arrives.

Top module: `ep_fifo_access_ctrl`

## Requirements
- R1: After reset the command register (address 0) reads 0x00. Its bits are bit0 request, bit1 direction, bit2 clear (always reads 0), bits4:3 endpoint select, bit5 SETUP flag, bit6 ready (read-only) and bit7 zero-length flag.
- R2: Select values 00, 01, 10 and 11 pick queues 0 to 3. The data port of queue n sits at address 4+n. An access to a data port whose n differs from the select is ignored and returns 0.
- R3: Writing request=1 with direction=1 opens a write job. While that job is open and the queue is not full, ready=1 and each data-port write appends one byte. Clearing the direction bit with the request still 1 ends the job: ready falls at once and does not return until the request has been dropped and raised again.
- R4: Writing request=1 with direction=0 opens a read job. While the queue is non-empty, ready=1 and each data-port read returns the oldest byte and removes it. A 0→1 edge of the direction bit under an active request marks the read as complete: ready stays 0 until the request is dropped and raised again.
- R5: A data-port access while ready=0 leaves the queue untouched. Such a read returns 0.
- R6: Each queue holds 8 bytes in arrival order. An engine push into a full queue is dropped. fifo_empty[n] and fifo_full[n] report the occupancy of queue n.
- R7: Writing the command register with bit2=1 empties the queue named by bits4:3 of that same write, whether or not ready is 1. Other queues are unaffected.
- R8: A pulse on eng_setup sets bit5. A register write with bit5=0 clears it, and a write with bit5=1 never sets it. If a set and a clear occur in the same cycle, the set wins.
- R9: A pulse on eng_zlp sets bit7, with the same clearing rules as R8.
- R10: In the status register (address 1), bit0 is set by eng_crc_err and cleared only by a status write with bit0=0.
- R11: Status bit1 mirrors eng_eot. Status bit2 reads 1 exactly when suspend=1 and eng_eot=0.
- R12: Status bit3 is the interrupt filter and resets to 0. One cycle after a token report, usb_irq pulses for one cycle if the token was not NAKed. With the filter at 0 it also pulses for a NAKed token on endpoint 0.
- R13: bus_reset clears the whole command register, including both flags and the select, and closes any job. Queue contents and the status register are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_reset | input | 1 | USB bus reset seen, one-cycle pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data ports) |
| reg_addr | input | 3 | 0 command, 1 status, 4..7 data ports |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| eng_push | input | 1 | Engine stores a received byte |
| eng_push_ep | input | 2 | Target queue of eng_push |
| eng_push_data | input | 8 | Byte stored by eng_push |
| eng_pop | input | 1 | Engine removes a byte for sending |
| eng_pop_ep | input | 2 | Queue addressed by eng_pop |
| eng_pop_data | output | 8 | Oldest byte of queue eng_pop_ep |
| fifo_empty | output | 4 | Per-queue empty flags |
| fifo_full | output | 4 | Per-queue full flags |
| eng_setup | input | 1 | SETUP packet landed in a queue |
| eng_zlp | input | 1 | Zero-length packet received |
| eng_crc_err | input | 1 | CRC error detected |
| eng_eot | input | 1 | End-of-transaction level, idles at 1 |
| suspend | input | 1 | Bus suspended |
| tok_valid | input | 1 | IN/OUT token report |
| tok_ep | input | 2 | Endpoint of the token |
| tok_nak | input | 1 | Token was answered with NAK |
| usb_irq | output | 1 | Interrupt pulse |

## Verification
A wrong handshake state shows up in bit6 of the command register in the same cycle that the register changes, or one cycle later for a job that is opening. A state that sticks or reopens therefore becomes visible on the first read after the direction edge. A pointer or count error shows up as a wrong byte or a wrong flag on the very next data-port or engine access. A flag that fails to stick, or that firmware can set by mistake, shows on the next register read. A wrong filter decision appears on usb_irq exactly one cycle after the token report.

// File: rtl/epfa_pkg.sv
package epfa_pkg;
    localparam int NUM_EP     = 4;
    localparam int EP_W       = 2;
    localparam int BYTE_W     = 8;
    localparam int FIFO_DEPTH = 8;
    localparam int ADDR_W     = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_STS = 3'd1;

    // command/status bit positions
    localparam int CTL_REQ   = 0;
    localparam int CTL_DIR   = 1;
    localparam int CTL_CLR   = 2;
    localparam int CTL_SEL   = 3;
    localparam int CTL_SETUP = 5;
    localparam int CTL_RDY   = 6;
    localparam int CTL_ZLP   = 7;

    // line status bit positions
    localparam int STS_CRC   = 0;
    localparam int STS_EOT   = 1;
    localparam int STS_FAULT = 2;
    localparam int STS_IRQC  = 3;

    typedef enum logic [2:0] {
        HS_IDLE,
        HS_WRITE,
        HS_WR_CLOSE,
        HS_READ,
        HS_RD_DONE
    } hs_state_t;
endpackage

// File: rtl/epfa_fifo.sv
module epfa_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_FULL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= push_data;
    end

    // R6: occupancy never exceeds the depth
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_FULL) else $error("queue count above depth");

    // R7: a clear always leaves the queue empty
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty) else $error("queue not empty after clear");

    // R6: a push into a full queue with no pop keeps it full and unchanged
    a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (full && $stable(wr_ptr)))
        else $error("push into full queue changed it");
endmodule

// File: rtl/epfa_handshake.sv
module epfa_handshake
    import epfa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic req,
    input  logic dir,
    output logic wr_open,
    output logic rd_open
);
    hs_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state_q <= HS_IDLE;
        else if (flush) state_q <= HS_IDLE;
        else            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: begin
                if (req && dir)       state_d = HS_WRITE;
                else if (req && !dir) state_d = HS_READ;
            end
            HS_WRITE: begin
                if (!req)      state_d = HS_IDLE;
                else if (!dir) state_d = HS_WR_CLOSE;
            end
            HS_WR_CLOSE: begin
                if (!req) state_d = HS_IDLE;
            end
            HS_READ: begin
                if (!req)     state_d = HS_IDLE;
                else if (dir) state_d = HS_RD_DONE;
            end
            HS_RD_DONE: begin
                if (!req) state_d = HS_IDLE;
            end
            default: state_d = HS_IDLE;
        endcase
    end

    always_comb begin
        wr_open = (state_q == HS_WRITE);
        rd_open = (state_q == HS_READ);
    end

    // R4: a completed read never reopens while the request stays up
    a_r4_read_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_RD_DONE && req && !flush) |=> !rd_open)
        else $error("read job reopened without new request");

    // R3: a closed write never reopens while the request stays up
    a_r3_write_close_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_WR_CLOSE && req && !flush) |=> !wr_open)
        else $error("write job reopened without new request");

    // R13: a bus reset leaves no job open
    a_r13_flush_idles: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!wr_open && !rd_open)) else $error("job open after bus reset");
endmodule

// File: rtl/epfa_irq.sv
module epfa_irq
    import epfa_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tok_valid,
    input  logic [EP_W-1:0] tok_ep,
    input  logic            tok_nak,
    input  logic            filter_on,
    output logic            usb_irq
);
    logic fire;

    always_comb begin
        fire = 1'b0;
        if (tok_valid) begin
            if (!tok_nak)                        fire = 1'b1;
            else if (!filter_on && tok_ep == '0) fire = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) usb_irq <= 1'b0;
        else        usb_irq <= fire;
    end

    // R12: NAKed tokens never interrupt with the filter on
    a_r12_nak_filtered: assert property (@(posedge clk) disable iff (!rst_n)
        (filter_on && tok_valid && tok_nak) |=> !usb_irq)
        else $error("interrupt on filtered NAK");

    // R12: data movement always interrupts
    a_r12_data_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !tok_nak) |=> usb_irq)
        else $error("missing interrupt on data token");
endmodule

// File: rtl/ep_fifo_access_ctrl.sv
module ep_fifo_access_ctrl
    import epfa_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_reset,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [BYTE_W-1:0]   reg_wdata,
    output logic [BYTE_W-1:0]   reg_rdata,
    input  logic                eng_push,
    input  logic [EP_W-1:0]     eng_push_ep,
    input  logic [BYTE_W-1:0]   eng_push_data,
    input  logic                eng_pop,
    input  logic [EP_W-1:0]     eng_pop_ep,
    output logic [BYTE_W-1:0]   eng_pop_data,
    output logic [NUM_EP-1:0]   fifo_empty,
    output logic [NUM_EP-1:0]   fifo_full,
    input  logic                eng_setup,
    input  logic                eng_zlp,
    input  logic                eng_crc_err,
    input  logic                eng_eot,
    input  logic                suspend,
    input  logic                tok_valid,
    input  logic [EP_W-1:0]     tok_ep,
    input  logic                tok_nak,
    output logic                usb_irq
);
    // command register state
    logic            req_q, dir_q, setup_q, zlp_q;
    logic [EP_W-1:0] sel_q;
    // status register state
    logic            crc_q, irqc_q;

    logic            wr_ctl, wr_sts, clr_pulse;
    logic [EP_W-1:0] clr_sel;
    logic            wr_open, rd_open, wr_act, rd_act, ready;
    logic            data_hit, mcu_push, mcu_pop, fault;
    logic [BYTE_W-1:0] head [NUM_EP];

    assign wr_ctl    = reg_wr && (reg_addr == ADDR_CTL);
    assign wr_sts    = reg_wr && (reg_addr == ADDR_STS);
    assign clr_pulse = wr_ctl && reg_wdata[CTL_CLR] && !bus_reset;
    assign clr_sel   = reg_wdata[CTL_SEL +: EP_W];
    assign fault     = suspend && !eng_eot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            dir_q   <= 1'b0;
            sel_q   <= '0;
            setup_q <= 1'b0;
            zlp_q   <= 1'b0;
        end else if (bus_reset) begin
            req_q   <= 1'b0;
            dir_q   <= 1'b0;
            sel_q   <= '0;
            setup_q <= 1'b0;
            zlp_q   <= 1'b0;
        end else begin
            if (wr_ctl) begin
                req_q <= reg_wdata[CTL_REQ];
                dir_q <= reg_wdata[CTL_DIR];
                sel_q <= reg_wdata[CTL_SEL +: EP_W];
            end
            setup_q <= eng_setup | (setup_q & (!wr_ctl | reg_wdata[CTL_SETUP]));
            zlp_q   <= eng_zlp   | (zlp_q   & (!wr_ctl | reg_wdata[CTL_ZLP]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q  <= 1'b0;
            irqc_q <= 1'b0;
        end else begin
            crc_q <= eng_crc_err | (crc_q & (!wr_sts | reg_wdata[STS_CRC]));
            if (wr_sts) irqc_q <= reg_wdata[STS_IRQC];
        end
    end

    epfa_handshake u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (bus_reset),
        .req     (req_q),
        .dir     (dir_q),
        .wr_open (wr_open),
        .rd_open (rd_open)
    );

    // job is live only while the register still asks for it
    assign wr_act   = wr_open && req_q && dir_q;
    assign rd_act   = rd_open && req_q && !dir_q;
    assign ready    = (wr_act && !fifo_full[sel_q]) || (rd_act && !fifo_empty[sel_q]);
    assign data_hit = reg_addr[ADDR_W-1] && (reg_addr[EP_W-1:0] == sel_q);
    assign mcu_push = reg_wr && data_hit && ready && wr_act;
    assign mcu_pop  = reg_rd && data_hit && ready && rd_act;

    for (genvar i = 0; i < NUM_EP; i++) begin : g_q
        logic mine_mcu_push, mine_mcu_pop, f_push, f_pop, f_clr;
        logic [BYTE_W-1:0] f_data;

        assign mine_mcu_push = mcu_push && (sel_q == EP_W'(i));
        assign mine_mcu_pop  = mcu_pop  && (sel_q == EP_W'(i));
        assign f_push = mine_mcu_push || (eng_push && eng_push_ep == EP_W'(i));
        assign f_data = mine_mcu_push ? reg_wdata : eng_push_data;
        assign f_pop  = mine_mcu_pop  || (eng_pop && eng_pop_ep == EP_W'(i));
        assign f_clr  = clr_pulse && (clr_sel == EP_W'(i));

        epfa_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (f_clr),
            .push      (f_push),
            .push_data (f_data),
            .pop       (f_pop),
            .head      (head[i]),
            .empty     (fifo_empty[i]),
            .full      (fifo_full[i])
        );
    end

    assign eng_pop_data = head[eng_pop_ep];

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTL) begin
            reg_rdata[CTL_REQ]            = req_q;
            reg_rdata[CTL_DIR]            = dir_q;
            reg_rdata[CTL_SEL +: EP_W]    = sel_q;
            reg_rdata[CTL_SETUP]          = setup_q;
            reg_rdata[CTL_RDY]            = ready;
            reg_rdata[CTL_ZLP]            = zlp_q;
        end else if (reg_addr == ADDR_STS) begin
            reg_rdata[STS_CRC]   = crc_q;
            reg_rdata[STS_EOT]   = eng_eot;
            reg_rdata[STS_FAULT] = fault;
            reg_rdata[STS_IRQC]  = irqc_q;
        end else if (data_hit && rd_act && ready) begin
            reg_rdata = head[sel_q];
        end
    end

    epfa_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tok_valid),
        .tok_ep    (tok_ep),
        .tok_nak   (tok_nak),
        .filter_on (irqc_q),
        .usb_irq   (usb_irq)
    );

    // R13: bus reset empties the command register
    a_r13_bus_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!req_q && !dir_q && sel_q == '0 && !setup_q && !zlp_q && !ready))
        else $error("command register not cleared by bus reset");

    // R8: SETUP flag holds until firmware writes 0 there
    a_r8_setup_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_q && !bus_reset && !(wr_ctl && !reg_wdata[CTL_SETUP])) |=> setup_q)
        else $error("SETUP flag lost");

    // R8: a SETUP pulse is never missed
    a_r8_setup_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_setup && !bus_reset) |=> setup_q) else $error("SETUP pulse missed");

    // R10: CRC flag captured
    a_r10_crc_captured: assert property (@(posedge clk) disable iff (!rst_n)
        eng_crc_err |=> crc_q) else $error("CRC error missed");

    // R3/R4: readiness needs an active request
    a_r4_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> req_q) else $error("ready without request");
endmodule

// File: tb/test_ep_fifo_access_ctrl.sv
module test_ep_fifo_access_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       eng_push = 1'b0, eng_pop = 1'b0;
    logic [1:0] eng_push_ep = '0, eng_pop_ep = '0;
    logic [7:0] eng_push_data = '0, eng_pop_data;
    logic [3:0] fifo_empty, fifo_full;
    logic       eng_setup = 1'b0, eng_zlp = 1'b0, eng_crc_err = 1'b0;
    logic       eng_eot = 1'b1, suspend = 1'b0;
    logic       tok_valid = 1'b0, tok_nak = 1'b0;
    logic [1:0] tok_ep = '0;
    logic       usb_irq;

    int tests = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ep_fifo_access_ctrl i_ep_fifo_access_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_push(eng_push), .eng_push_ep(eng_push_ep), .eng_push_data(eng_push_data),
        .eng_pop(eng_pop), .eng_pop_ep(eng_pop_ep), .eng_pop_data(eng_pop_data),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .eng_setup(eng_setup), .eng_zlp(eng_zlp), .eng_crc_err(eng_crc_err),
        .eng_eot(eng_eot), .suspend(suspend),
        .tok_valid(tok_valid), .tok_ep(tok_ep), .tok_nak(tok_nak),
        .usb_irq(usb_irq)
    );

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] ctlv(input bit req, input bit dir, input bit clr,
                                        input logic [1:0] sel);
        return {3'b000, sel, clr, dir, req};
    endfunction

    function automatic logic [7:0] pat(input int ep, input int i, input int n);
        return 8'((ep * 37 + i * 11 + n * 5) & 255);
    endfunction

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic epush(input logic [1:0] ep, input logic [7:0] d);
        @(negedge clk);
        eng_push = 1'b1; eng_push_ep = ep; eng_push_data = d;
        @(negedge clk);
        eng_push = 1'b0;
    endtask

    task automatic epop(input logic [1:0] ep, output logic [7:0] d);
        @(negedge clk);
        eng_pop = 1'b1; eng_pop_ep = ep;
        #1 d = eng_pop_data;
        @(negedge clk);
        eng_pop = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R11 idle line status
        peek(3'd0, d); chk("R1 reset command reg", d, 8'h00);
        peek(3'd1, d); chk("R11 reset status reg", d, 8'h02);
        chk("R6 reset empty", {4'b0, fifo_empty}, 8'h0f);
        chk("R6 reset full", {4'b0, fifo_full}, 8'h00);

        // R4/R5/R6 read path sweep over every queue and several fills
        for (int ep = 0; ep < 4; ep++) begin
            for (int k = 0; k < 4; k++) begin
                int n = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 5 : 8;
                for (int i = 0; i < n; i++) epush(2'(ep), pat(ep, i, n));
                if (n == 8) epush(2'(ep), 8'hee);   // R6 dropped when full
                chk("R6 full flag", {7'b0, fifo_full[ep]}, {7'b0, n == 8});
                reg_write(3'd0, ctlv(1, 0, 0, 2'(ep)));
                peek(3'd0, d);
                chk("R4 ready on open read", d, ctlv(1, 0, 0, 2'(ep)) | ((n > 0) ? 8'h40 : 8'h00));
                for (int i = 0; i < n; i++) begin
                    reg_read(3'(4 + ep), d);
                    chk("R4 read byte order", d, pat(ep, i, n));
                end
                peek(3'd0, d);
                chk("R5 ready low when drained", {7'b0, d[6]}, 8'h00);
                reg_read(3'(4 + ep), d);
                chk("R5 read while not ready", d, 8'h00);
                chk("R5 queue still empty", {7'b0, fifo_empty[ep]}, 8'h01);
                // read complete: direction 0->1 with request held
                reg_write(3'd0, ctlv(1, 1, 0, 2'(ep)));
                epush(2'(ep), 8'h5a);
                peek(3'd0, d);
                chk("R4 no reopen after read done", {7'b0, d[6]}, 8'h00);
                reg_write(3'd0, ctlv(0, 0, 0, 2'(ep)));
                epop(2'(ep), d);
                chk("R6 engine pop", d, 8'h5a);
            end
        end

        // R2 access to a non-selected data port
        epush(2'd1, 8'h11);
        epush(2'd2, 8'h22);
        reg_write(3'd0, ctlv(1, 0, 0, 2'd1));
        reg_read(3'd6, d);
        chk("R2 foreign port reads 0", d, 8'h00);
        chk("R2 foreign queue untouched", {7'b0, fifo_empty[2]}, 8'h00);
        reg_read(3'd5, d);
        chk("R2 select 01 reaches queue 1", d, 8'h11);
        reg_write(3'd0, ctlv(0, 0, 0, 2'd1));
        epop(2'd2, d);
        chk("R2 foreign byte intact", d, 8'h22);

        // R3 write path sweep
        for (int ep = 0; ep < 4; ep++) begin
            reg_write(3'd0, ctlv(1, 1, 0, 2'(ep)));
            peek(3'd0, d);
            chk("R3 ready on open write", d, ctlv(1, 1, 0, 2'(ep)) | 8'h40);
            for (int i = 0; i < 8; i++) reg_write(3'(4 + ep), pat(ep, i, 9));
            peek(3'd0, d);
            chk("R3 ready low when full", {7'b0, d[6]}, 8'h00);
            reg_write(3'(4 + ep), 8'hff);         // R5 ignored
            chk("R3 full flag", {7'b0, fifo_full[ep]}, 8'h01);
            reg_write(3'd0, ctlv(1, 0, 0, 2'(ep)));  // end of write job
            epop(2'(ep), d);
            chk("R3 first byte", d, pat(ep, 0, 9));
            peek(3'd0, d);
            chk("R3 ready stays low after close", {7'b0, d[6]}, 8'h00);
            reg_write(3'(4 + ep), 8'hfe);         // must be ignored
            reg_write(3'd0, ctlv(0, 0, 0, 2'(ep)));
            for (int i = 1; i < 8; i++) begin
                epop(2'(ep), d);
                chk("R3 byte order", d, pat(ep, i, 9));
            end
            chk("R5 write after close ignored", {7'b0, fifo_empty[ep]}, 8'h01);
        end

        // R7 clear
        for (int i = 0; i < 3; i++) epush(2'd3, 8'(i));
        epush(2'd0, 8'h77);
        reg_write(3'd0, ctlv(0, 0, 1, 2'd0));
        chk("R7 selected queue emptied", {7'b0, fifo_empty[0]}, 8'h01);
        chk("R7 other queue kept", {7'b0, fifo_empty[3]}, 8'h00);
        reg_write(3'd0, ctlv(0, 0, 1, 2'd3));
        chk("R7 clear without ready", {7'b0, fifo_empty[3]}, 8'h01);
        peek(3'd0, d);
        chk("R7 clear bit reads 0", d, 8'h18);

        // R8 SETUP flag
        reg_write(3'd0, 8'h00);
        reg_write(3'd0, 8'h20);
        peek(3'd0, d); chk("R8 firmware cannot set", d, 8'h00);
        @(negedge clk); eng_setup = 1'b1; @(negedge clk); eng_setup = 1'b0;
        peek(3'd0, d); chk("R8 set by engine", d, 8'h20);
        reg_write(3'd0, 8'h20);
        peek(3'd0, d); chk("R8 write 1 keeps", d, 8'h20);
        reg_write(3'd0, 8'h00);
        peek(3'd0, d); chk("R8 write 0 clears", d, 8'h00);
        @(negedge clk);
        eng_setup = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00;
        @(negedge clk); eng_setup = 1'b0; reg_wr = 1'b0;
        peek(3'd0, d); chk("R8 set beats clear", d, 8'h20);
        reg_write(3'd0, 8'h00);

        // R9 zero-length flag
        @(negedge clk); eng_zlp = 1'b1; @(negedge clk); eng_zlp = 1'b0;
        peek(3'd0, d); chk("R9 set by engine", d, 8'h80);
        reg_write(3'd0, 8'h80);
        peek(3'd0, d); chk("R9 write 1 keeps", d, 8'h80);
        reg_write(3'd0, 8'h00);
        peek(3'd0, d); chk("R9 write 0 clears", d, 8'h00);

        // R10 CRC flag
        @(negedge clk); eng_crc_err = 1'b1; @(negedge clk); eng_crc_err = 1'b0;
        peek(3'd1, d); chk("R10 crc set", d, 8'h03);
        reg_write(3'd1, 8'h01);
        peek(3'd1, d); chk("R10 write 1 keeps", d, 8'h03);
        reg_write(3'd1, 8'h00);
        peek(3'd1, d); chk("R10 write 0 clears", d, 8'h02);

        // R11 end of transaction and fault
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); eng_eot = s[0]; suspend = s[1];
            peek(3'd1, d);
            chk("R11 eot/fault", d, {5'b0, (s[1] && !s[0]), s[0], 1'b0});
        end
        @(negedge clk); eng_eot = 1'b1; suspend = 1'b0;

        // R12 interrupt filter sweep
        for (int f = 0; f < 2; f++) begin
            reg_write(3'd1, f[0] ? 8'h08 : 8'h00);
            peek(3'd1, d); chk("R12 filter bit", d, f[0] ? 8'h0a : 8'h02);
            for (int ep = 0; ep < 4; ep++) begin
                for (int nk = 0; nk < 2; nk++) begin
                    @(negedge clk);
                    tok_valid = 1'b1; tok_ep = 2'(ep); tok_nak = nk[0];
                    @(negedge clk);
                    tok_valid = 1'b0;
                    chk("R12 irq pulse", {7'b0, usb_irq},
                        {7'b0, (nk == 0) || (f == 0 && ep == 0)});
                    @(negedge clk);
                    chk("R12 irq one cycle", {7'b0, usb_irq}, 8'h00);
                end
            end
        end
        reg_write(3'd1, 8'h00);

        // R13 bus reset
        epush(2'd1, 8'h99);
        reg_write(3'd0, ctlv(1, 1, 0, 2'd2));
        @(negedge clk); eng_setup = 1'b1; @(negedge clk); eng_setup = 1'b0;
        peek(3'd0, d); chk("R13 before bus reset", d, 8'h73);
        @(negedge clk); bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
        peek(3'd0, d); chk("R13 command reg cleared", d, 8'h00);
        chk("R13 queue contents kept", {7'b0, fifo_empty[1]}, 8'h00);
        epop(2'd1, d); chk("R13 byte survives", d, 8'h99);

        finish_run();
    end
endmodule